// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit logical address into a physical address. It walks a page table with two levels, reading the entries through a simple memory read port. The logical page is 1 KB. The address is split into an outer index, an inner index and a page offset. The outer index selects one word in a top-level table, and that table starts at the configured table base. The word it finds points at an inner table page. The inner index then picks the leaf word, which gives the frame. The physical address is that frame with the offset attached unchanged.

A second configuration input holds the number of outer entries that are in use. An outer index that is not below this length fails straight away, with no memory traffic. Both levels carry a valid bit, and the leaf word also carries a write-permission bit. Each failure is reported with its own cause code. The walker serves one request at a time and marks the end of each one with a single-cycle done strobe, together with either the physical address or a fault code. It keeps no copies of past translations and it contains no memory of its own.

Top module: `ptwalk_unit`

## Requirements
- R1: After reset, and at any time no walk is in progress, `busy`, `done` and `mem_req` are low.
- R2: Logical address fields are: offset = bits [9:0], inner index = bits [19:10], outer index = bits [31:20]. A walk that succeeds returns `done_paddr` = {leaf word bits [31:10], logical bits [9:0]} with `done_fault` = 0.
- R3: The first read is at `cfg_tbase` + 4 × outer index. The second read is at {outer word bits [31:10], ten zero bits} + 4 × inner index. A walk that succeeds makes exactly these two reads, in this order.
- R4: When the outer index is greater than or equal to `cfg_tlen`, the walk ends with fault code 1 and makes no memory read. This includes the case `cfg_tlen` = 0. An outer index of `cfg_tlen` − 1 is walked normally.
- R5: An outer word with bit 0 (valid) clear ends the walk with fault code 2 after exactly one read.
- R6: A leaf word with bit 0 (valid) clear ends the walk with fault code 3 after two reads.
- R7: When `req_write` = 1 and the leaf word has bit 1 (writable) clear, the walk ends with fault code 4. A read of such a page succeeds. Bit 1 of the outer word has no effect: a write through an outer word with bit 1 clear succeeds when the leaf word allows it.
- R8: Once `mem_req` is raised, it stays high and `mem_addr` stays unchanged until the cycle in which `mem_ack` is seen. Any number of wait cycles is accepted.
- R9: Every accepted request produces exactly one `done` pulse, one cycle wide. When `done_fault` is nonzero, `done_paddr` is 0. Fault codes are limited to 0 to 4.
- R10: A `req_valid` that arrives while `busy` is high is ignored. The walk in progress returns its own result, and no second `done` follows.
- R11: Causes are ranked in this order: length, then outer invalid, then leaf invalid, then write protection. A write that hits an invalid leaf word that is also read-only reports code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tbase | input | 32 | Physical byte address of the outer table, word aligned |
| cfg_tlen | input | 13 | Number of valid outer entries |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion strobe |
| done_paddr | output | 32 | Translated physical address, 0 on fault |
| done_fault | output | 3 | 0 ok, 1 length, 2 outer invalid, 3 leaf invalid, 4 write protect |
| mem_req | output | 1 | Table word read request |
| mem_addr | output | 32 | Byte address of the table word |
| mem_ack | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Table word returned with `mem_ack` |

## Verification
The properties assume three things about the inputs. `mem_ack` is only raised while `mem_req` is high, and only for a single cycle per read. `mem_rdata` is valid in that same cycle. `cfg_tbase` and `cfg_tlen` do not change while a walk is in progress. The bench memory model meets all three: it answers a pending request after a chosen number of wait cycles, it drops the acknowledge on the cycle after it raises it, and it samples the read data together with the acknowledge. The configuration is changed only between walks, after `done` has been seen.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_t;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LEN   = 3'd1,
    FLT_OUTER = 3'd2,
    FLT_INNER = 3'd3,
    FLT_WPROT = 3'd4
  } walk_fault_t;

  // Flag positions inside a table word; the leaf decoder and the bench rely on them
  localparam int unsigned ENT_VALID_BIT = 0;
  localparam int unsigned ENT_WRITE_BIT = 1;

endpackage

// File: rtl/ptw_split.sv
// Address arithmetic: field extraction, length compare and table word addresses
module ptw_split #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned IN_W  = 10,
  localparam int unsigned OUT_W = VA_W - OFF_W - IN_W,
  localparam int unsigned SLOT_LG2 = $clog2(PA_W / 8)
) (
  input  logic [VA_W-1:0]  new_va,
  input  logic [VA_W-1:0]  cur_va,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [OUT_W:0]   tbl_len,
  input  logic [PA_W-1:0]  inner_base,
  output logic             len_viol,
  output logic [PA_W-1:0]  outer_addr,
  output logic [PA_W-1:0]  inner_addr
);

  function automatic logic [OUT_W-1:0] outer_of(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: OUT_W];
  endfunction

  function automatic logic [IN_W-1:0] inner_of(input logic [VA_W-1:0] va);
    return va[OFF_W +: IN_W];
  endfunction

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                input logic [PA_W-1:0] idx);
    return base + (idx << SLOT_LG2);
  endfunction

  logic [VA_W-OUT_W-1:0] unused_low;
  logic [OFF_W-1:0]      unused_off;
  assign unused_low = new_va[VA_W-OUT_W-1:0];
  assign unused_off = cur_va[OFF_W-1:0];

  assign len_viol   = {1'b0, outer_of(new_va)} >= tbl_len;
  assign outer_addr = slot_addr(tbl_base,   PA_W'(outer_of(cur_va)));
  assign inner_addr = slot_addr(inner_base, PA_W'(inner_of(cur_va)));

endmodule

// File: rtl/ptw_entry.sv
// Table word decode: valid flag, write permission, next-level base
module ptw_entry
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 10
) (
  input  logic [PA_W-1:0] ent,
  input  logic            is_write,
  output logic            ent_valid,
  output logic            ent_wprot,
  output logic [PA_W-1:0] ent_base
);

  logic [OFF_W-3:0] unused_mid;
  assign unused_mid = ent[OFF_W-1:2];

  assign ent_valid = ent[ENT_VALID_BIT];
  assign ent_wprot = is_write && !ent[ENT_WRITE_BIT];
  assign ent_base  = {ent[PA_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/ptw_ctrl.sv
// Walk sequencer and result registers
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic            len_viol,
  input  logic            mem_ack,
  input  logic            ent_valid,
  input  logic            ent_wprot,
  input  logic [PA_W-1:0] ent_base,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic            sel_inner,
  output logic [VA_W-1:0] cur_va,
  output logic            cur_wr,
  output logic [PA_W-1:0] inner_base,
  output logic [PA_W-1:0] res_paddr,
  output logic [2:0]      res_fault,
  output logic            ev_accept,
  output logic            ev_outer_ack,
  output logic            ev_inner_ack
);

  function automatic logic [PA_W-1:0] join_pa(input logic [PA_W-1:0] frame,
                                              input logic [VA_W-1:0] va);
    return frame | PA_W'(va[OFF_W-1:0]);
  endfunction

  walk_state_t state_q;
  walk_fault_t fault_q;

  assign ev_accept    = (state_q == ST_IDLE) && req_valid;
  assign ev_outer_ack = (state_q == ST_OUTER) && mem_ack;
  assign ev_inner_ack = (state_q == ST_INNER) && mem_ack;

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign mem_req   = (state_q == ST_OUTER) || (state_q == ST_INNER);
  assign sel_inner = (state_q == ST_INNER);
  assign res_fault = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fault_q    <= FLT_NONE;
      cur_va     <= '0;
      cur_wr     <= 1'b0;
      inner_base <= '0;
      res_paddr  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            cur_va <= req_vaddr;
            cur_wr <= req_write;
            if (len_viol) begin
              fault_q   <= FLT_LEN;
              res_paddr <= '0;
              state_q   <= ST_DONE;
            end else begin
              state_q <= ST_OUTER;
            end
          end
        end
        ST_OUTER: begin
          if (mem_ack) begin
            if (!ent_valid) begin
              fault_q   <= FLT_OUTER;
              res_paddr <= '0;
              state_q   <= ST_DONE;
            end else begin
              inner_base <= ent_base;
              state_q    <= ST_INNER;
            end
          end
        end
        ST_INNER: begin
          if (mem_ack) begin
            state_q <= ST_DONE;
            if (!ent_valid) begin
              fault_q   <= FLT_INNER;
              res_paddr <= '0;
            end else if (ent_wprot) begin
              fault_q   <= FLT_WPROT;
              res_paddr <= '0;
            end else begin
              fault_q   <= FLT_NONE;
              res_paddr <= join_pa(ent_base, cur_va);
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptwalk_unit.sv
module ptwalk_unit #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_OFF_W = 10,
  parameter int unsigned INNER_W  = 10,
  localparam int unsigned OUTER_W = VA_W - PG_OFF_W - INNER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  cfg_tbase,
  input  logic [OUTER_W:0] cfg_tlen,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             busy,
  output logic             done,
  output logic [PA_W-1:0]  done_paddr,
  output logic [2:0]       done_fault,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [PA_W-1:0]  mem_rdata
);

  // Internal events, named for the bound checker
  logic            ev_accept;
  logic            ev_len_fault;
  logic            ev_outer_ack;
  logic            ev_inner_ack;
  logic            ent_valid;
  logic            ent_wprot;
  logic [PA_W-1:0] ent_base;
  logic [VA_W-1:0] cur_va;
  logic            cur_wr;
  logic            sel_inner;
  logic [PA_W-1:0] inner_base;
  logic [PA_W-1:0] outer_addr;
  logic [PA_W-1:0] inner_addr;

  ptw_split #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(PG_OFF_W), .IN_W(INNER_W)
  ) u_split (
    .new_va     (req_vaddr),
    .cur_va     (cur_va),
    .tbl_base   (cfg_tbase),
    .tbl_len    (cfg_tlen),
    .inner_base (inner_base),
    .len_viol   (ev_len_fault),
    .outer_addr (outer_addr),
    .inner_addr (inner_addr)
  );

  ptw_entry #(.PA_W(PA_W), .OFF_W(PG_OFF_W)) u_entry (
    .ent       (mem_rdata),
    .is_write  (cur_wr),
    .ent_valid (ent_valid),
    .ent_wprot (ent_wprot),
    .ent_base  (ent_base)
  );

  ptw_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(PG_OFF_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_write    (req_write),
    .len_viol     (ev_len_fault),
    .mem_ack      (mem_ack),
    .ent_valid    (ent_valid),
    .ent_wprot    (ent_wprot),
    .ent_base     (ent_base),
    .busy         (busy),
    .done         (done),
    .mem_req      (mem_req),
    .sel_inner    (sel_inner),
    .cur_va       (cur_va),
    .cur_wr       (cur_wr),
    .inner_base   (inner_base),
    .res_paddr    (done_paddr),
    .res_fault    (done_fault),
    .ev_accept    (ev_accept),
    .ev_outer_ack (ev_outer_ack),
    .ev_inner_ack (ev_inner_ack)
  );

  assign mem_addr = sel_inner ? inner_addr : outer_addr;

endmodule

// File: rtl/ptwalk_chk.sv
module ptwalk_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic [2:0]      done_fault,
  input logic [OFF_W-1:0] pa_off,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_ack,
  input logic            ev_accept,
  input logic            ev_len_fault,
  input logic            ev_outer_ack,
  input logic            ev_inner_ack,
  input logic            ent_ok,
  input logic [VA_W-1:0] cur_va
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  fault_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_fault <= 3'd4));

  // R4
  len_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_len_fault) |=> (done && done_fault == 3'd1 && !mem_req));

  // R5
  outer_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_outer_ack && !ent_ok) |=> (done && done_fault == 3'd2));

  // R6
  inner_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inner_ack && !ent_ok) |=> (done && done_fault == 3'd3));

  // R10
  hold_va_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_va));

  // R2
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault == 3'd0) |-> (pa_off == cur_va[OFF_W-1:0]));

endmodule

bind ptwalk_unit ptwalk_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(PG_OFF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .done_fault   (done_fault),
  .pa_off       (done_paddr[PG_OFF_W-1:0]),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_ack      (mem_ack),
  .ev_accept    (ev_accept),
  .ev_len_fault (ev_len_fault),
  .ev_outer_ack (ev_outer_ack),
  .ev_inner_ack (ev_inner_ack),
  .ent_ok       (ent_valid),
  .cur_va       (cur_va)
);

// File: tb/ptwalk_unit_bench.sv
module ptwalk_unit_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_tbase = 32'h0000_0100;
  logic [12:0] cfg_tlen = 13'd8;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        busy, done;
  logic [31:0] done_paddr;
  logic [2:0]  done_fault;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  ptwalk_unit u_ptwalk_unit (
    .clk(clk), .rst_n(rst_n), .cfg_tbase(cfg_tbase), .cfg_tlen(cfg_tlen),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .busy(busy), .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  int done_cnt = 0;
  int read_cnt = 0;
  int stab_err = 0;
  logic [31:0] rd_log [0:3];
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [31:0] mem [0:2047];

  // Behavioural memory with a programmable number of wait cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt >= lat) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr[12:2]];
          wcnt      <= 0;
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  // Port monitor: pre-edge values
  always @(posedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (mem_req && mem_ack) begin
        if (read_cnt < 4) rd_log[read_cnt] = mem_addr;
        read_cnt++;
      end
      if (prev_pend && (!mem_req || mem_addr != prev_addr)) stab_err++;
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
    end
  end

  function automatic logic [31:0] mk_va(input int o, input int i, input int off);
    return {o[11:0], i[9:0], off[9:0]};
  endfunction

  function automatic logic [31:0] pte(input logic [31:0] base, input logic w, input logic v);
    return {base[31:10], 8'h00, w, v};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] va, input logic wr, input int lat_v,
                         input logic [2:0] exp_f, input logic [31:0] exp_pa,
                         input int exp_reads, input string tag);
    bit seen = 0;
    lat = lat_v;
    @(negedge clk);
    done_cnt = 0;
    read_cnt = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, {tag, " done seen"}, 32'(seen), 32'd1);
    if (seen) begin
      chk(done_fault == exp_f, {tag, " fault code"}, 32'(done_fault), 32'(exp_f));
      chk(done_paddr == exp_pa, {tag, " physical address"}, done_paddr, exp_pa);
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, {tag, " R9 done pulses"}, 32'(done_cnt), 32'd1);
    chk(read_cnt == exp_reads, {tag, " read count"}, 32'(read_cnt), 32'(exp_reads));
  endtask

  task automatic t_reset();
    chk(!busy, "R1 busy after reset", 32'(busy), 32'd0);
    chk(!done, "R1 done after reset", 32'(done), 32'd0);
    chk(!mem_req, "R1 mem_req after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_translate();
    // R2 R3: read through outer 0 / inner 0, outer word read-only bit ignored
    run_req(mk_va(0, 0, 'h155), 1'b0, 0, 3'd0, 32'h0004_8155, 2, "R2 read ok");
    chk(rd_log[0] == 32'h0000_0100, "R3 outer word address", rd_log[0], 32'h0000_0100);
    chk(rd_log[1] == 32'h0000_1000, "R3 inner word address", rd_log[1], 32'h0000_1000);
    // R7: write allowed by leaf though outer bit 1 is clear; max offset
    run_req(mk_va(0, 0, 'h3FF), 1'b1, 2, 3'd0, 32'h0004_83FF, 2, "R7 write to writable");
    run_req(mk_va(0, 3, 'h001), 1'b0, 1, 3'd0, 32'hABCD_E401, 2, "R7 read of read-only");
    run_req(mk_va(0, 3, 'h010), 1'b1, 3, 3'd4, 32'h0, 2, "R7 write to read-only");
  endtask

  task automatic t_length();
    run_req(mk_va(8, 0, 0), 1'b0, 0, 3'd1, 32'h0, 0, "R4 index equals length");
    run_req(mk_va('hFFF, 0, 0), 1'b1, 0, 3'd1, 32'h0, 0, "R4 top index");
    run_req(mk_va(7, 2, 'h2A), 1'b0, 1, 3'd0, 32'h1234_5C2A, 2, "R4 last legal index");
    chk(rd_log[0] == 32'h0000_011C, "R3 last outer address", rd_log[0], 32'h0000_011C);
    chk(rd_log[1] == 32'h0000_1408, "R3 second inner address", rd_log[1], 32'h0000_1408);
    @(negedge clk);
    cfg_tlen = 13'd0;
    run_req(mk_va(0, 0, 0), 1'b0, 0, 3'd1, 32'h0, 0, "R4 zero length");
    @(negedge clk);
    cfg_tlen = 13'd8;
  endtask

  task automatic t_invalid();
    run_req(mk_va(1, 0, 'h40), 1'b0, 2, 3'd2, 32'h0, 1, "R5 outer invalid");
    run_req(mk_va(0, 5, 0), 1'b0, 1, 3'd3, 32'h0, 2, "R6 inner invalid");
    run_req(mk_va(0, 5, 'h8), 1'b1, 0, 3'd3, 32'h0, 2, "R11 invalid beats write protect");
  endtask

  task automatic t_busy_ignore();
    bit seen = 0;
    lat = 3;
    @(negedge clk);
    done_cnt = 0;
    read_cnt = 0;
    req_valid = 1'b1;
    req_vaddr = mk_va(0, 0, 'h020);
    req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;               // second request while busy
    req_vaddr = mk_va(1, 0, 0);
    req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen && done_fault == 3'd0, "R10 first walk result code", 32'(done_fault), 32'd0);
    chk(done_paddr == 32'h0004_8020, "R10 first walk address", done_paddr, 32'h0004_8020);
    repeat (12) @(negedge clk);
    chk(done_cnt == 1, "R10 no second done", 32'(done_cnt), 32'd1);
    chk(!busy, "R1 idle after ignored request", 32'(busy), 32'd0);
  endtask

  initial begin
    for (int a = 0; a < 2048; a++) mem[a] = '0;
    // Outer table at 0x100 (word index 0x40); bit 1 left clear on purpose
    mem['h40] = pte(32'h0000_1000, 1'b0, 1'b1);           // outer 0
    mem['h41] = 32'h0000_1400;                            // outer 1 invalid
    mem['h47] = pte(32'h0000_1400, 1'b0, 1'b1);           // outer 7
    // Inner table at 0x1000 (word index 0x400)
    mem['h400] = pte(32'h0004_8000, 1'b1, 1'b1);
    mem['h403] = pte(32'hABCD_E400, 1'b0, 1'b1);
    mem['h405] = 32'h0000_0000;                           // invalid, read-only
    // Inner table at 0x1400 (word index 0x500)
    mem['h502] = pte(32'h1234_5C00, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_length();
    t_invalid();
    t_busy_ignore();
    chk(stab_err == 0, "R8 request held stable until ack", 32'(stab_err), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule